// File: doc/BRIEF.md
# Charge-Transfer Capacitive Sense Sequencer

This block runs one charge-transfer measurement burst over up to eight sensing groups at the same time. Each group has an electrode switch and a sampling-capacitor switch. After a start strobe, the block latches its configuration. It discharges every enabled capacitor and then repeats a charge / dead-time / transfer / dead-time cycle. Each group's synchronized threshold input is watched during the charge phases. A group's transfer count is frozen at the first charge phase in which its input is seen high. Groups still waiting when the transfer count passes the programmed maximum all receive the timeout value.

The control path is a single Moore state machine with eight states: `S_IDLE`, `S_DISCH` (discharge wait), `S_DEAD0` (first dead time), `S_CHARGE`, `S_DEAD1`, `S_XFER` (transfer), `S_DEAD2` and `S_DONE`. The transitions are:
- `S_IDLE` goes to `S_DISCH` on a start with a non-empty pending set, and to `S_DONE` on a start with an empty pending set.
- `S_DISCH` goes to `S_DEAD0`, and `S_DEAD0` goes to `S_CHARGE`, each when its timer expires.
- `S_CHARGE` goes to `S_DEAD1`, and `S_DEAD1` goes to `S_XFER`, each on timer expiry. The transfer counter steps on entry to `S_XFER`.
- `S_XFER` goes to `S_DEAD2` on timer expiry.
- `S_DEAD2` goes to `S_DONE` when all pending groups have been captured ("all captured"). It also goes to `S_DONE` when the count exceeds the maximum ("timeout"), after filling every group still waiting. Otherwise it loops back to `S_CHARGE`.
- `S_DONE` always returns to `S_IDLE`.

A phase timer sets the length of every timed state. A zero delay setting counts as one clock. Dead time is the parameter `DEAD_CYC`, with a minimum of one clock. An optional spread stepper lengthens each charge phase by a value that walks upward from a minimum and wraps back to it. The pins are driven low whenever the block is idle.

Top module: `ctsense_seq`

## Requirements
- R1: After reset, `chg_o` and `xfer_o` are all zero, `low_o` is all ones, `busy_o` and `done_o` are low and every count is zero.
- R2: After an accepted start, all groups are driven low with no switch closed for `disch_dly_i` clocks, then for `DEAD_CYC` clocks. Only after that does the first charge phase begin. `chg_o` and `xfer_o` are never non-zero in the same clock or in adjacent clocks.
- R3: During charge, `chg_o` equals `elec_en_i & ~off_i`. During transfer, `xfer_o` equals `(elec_en_i | samp_en_i) & ~off_i`. Both masks are latched at start.
- R4: The pending set is `samp_en_i & ~off_i & ~burst_only_i`. A burst-only group toggles its switches but its count stays 0.
- R5: A group with `off_i` set never raises `chg_o` or `xfer_o`, keeps `low_o` high for the whole burst, and its count stays 0.
- R6: A pending group's count equals the number of completed transfers before the first charge phase in which its synchronized threshold is seen high. A threshold already high at start gives 0.
- R7: The burst ends after the transfer that follows the charge phase in which the last pending group was captured. The total number of transfers is then the largest captured count plus one.
- R8: If the transfer count exceeds `max_count_i` (at most 2^CNT_W-2), every pending group not yet captured receives `max_count_i + 1`. The burst then ends after exactly `max_count_i + 1` transfers.
- R9: If the pending set is empty at start, no switch output changes and `done_o` still pulses once.
- R10: Every accepted start clears all counts, so a group not captured in the new burst reads 0.
- R11: With `spread_en_i` set, the k-th charge phase lasts `charge_dly_i + e_k` clocks. The first value e_1 is `spread_min_i + 1`, and each later value is the previous one plus 1, replaced by `spread_min_i` when it would equal `spread_max_i`. With spread off, every charge phase lasts `charge_dly_i` clocks.
- R12: A start strobe or a change of any configuration input while `busy_o` is high has no effect on the running burst.
- R13: `done_o` is high for exactly one clock per burst. In that clock and afterwards, the outputs are in the drive-low idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| elec_en_i | input | GROUPS | Electrode enable per group |
| samp_en_i | input | GROUPS | Sampling-capacitor enable per group |
| off_i | input | GROUPS | Group switched off |
| burst_only_i | input | GROUPS | Group toggles but is not measured |
| max_count_i | input | CNT_W | Maximum transfer count |
| charge_dly_i | input | DLY_W | Charge phase length in clocks |
| xfer_dly_i | input | DLY_W | Transfer phase length in clocks |
| disch_dly_i | input | DLY_W | Discharge wait length in clocks |
| spread_en_i | input | 1 | Enable charge-phase spreading |
| spread_min_i | input | SPR_W | Spread stepper minimum |
| spread_max_i | input | SPR_W | Spread stepper wrap value |
| thr_i | input | GROUPS | Asynchronous threshold inputs |
| chg_o | output | GROUPS | Electrode driven high (charge) |
| xfer_o | output | GROUPS | Transfer switches closed |
| low_o | output | GROUPS | Group pins driven low |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-clock end-of-burst pulse |
| count_o | output | GROUPS*CNT_W | Per-group captured counts, group g at bits g*CNT_W upward |

## Verification
Corruption of the pending or captured masks shows at the ports as a wrong transfer total. The burst then ends one transfer too early, or runs on to the timeout. Either way the count bus disagrees with the model at the single `done_o` pulse. A state register that skips a dead time shows up within one clock as a charge and a transfer pulse in adjacent clocks. A wrong spread step changes the length of the second or third charge pulse, so it is seen within the first few cycles of a burst.

// File: rtl/ctsense_pkg.sv
package ctsense_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DISCH,
        S_DEAD0,
        S_CHARGE,
        S_DEAD1,
        S_XFER,
        S_DEAD2,
        S_DONE
    } cts_state_e;

endpackage

// File: rtl/ctsense_sync.sv
module ctsense_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[b] <= 1'b0;
                sync_q[b] <= 1'b0;
            end else begin
                meta_q[b] <= d_i[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/ctsense_timer.sv
module ctsense_timer #(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [LW-1:0] len_i,
    output logic          expire_o
);

    logic [LW-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= (len_i == '0) ? '0 : len_i - LW'(1);
        end else if (rem_q != '0) begin
            rem_q <= rem_q - LW'(1);
        end
    end

    assign expire_o = (rem_q == '0);

    // A phase longer than one clock must not end in the clock after it starts
    assert_phase_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i > LW'(1)) |=> !expire_o);

endmodule

// File: rtl/ctsense_spread.sv
module ctsense_spread #(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          en_i,
    input  logic [SW-1:0] min_i,
    input  logic [SW-1:0] max_i,
    input  logic          step_i,
    output logic [SW-1:0] extra_o
);

    logic          en_q;
    logic [SW-1:0] min_q;
    logic [SW-1:0] max_q;
    logic [SW-1:0] sp_q;
    logic [SW-1:0] inc;
    logic [SW-1:0] nxt;

    assign inc = sp_q + SW'(1);
    assign nxt = (inc == max_q) ? min_q : inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            min_q <= '0;
            max_q <= '0;
            sp_q  <= '0;
        end else if (init_i) begin
            en_q  <= en_i;
            min_q <= min_i;
            max_q <= max_i;
            sp_q  <= min_i;
        end else if (step_i && en_q) begin
            sp_q  <= nxt;
        end
    end

    assign extra_o = en_q ? nxt : '0;

    assert_spread_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (min_q < max_q) |-> (sp_q >= min_q && sp_q < max_q));

endmodule

// File: rtl/ctsense_capture.sv
module ctsense_capture #(
    parameter int G  = 8,
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            sample_i,
    input  logic            fill_i,
    input  logic [G-1:0]    thr_i,
    input  logic [G-1:0]    pend_i,
    input  logic [CW-1:0]   xcnt_i,
    output logic [G-1:0]    cap_o,
    output logic [G*CW-1:0] cnt_o
);

    logic [G-1:0]  cap_q;
    logic [CW-1:0] cnt_q [G];

    for (genvar g = 0; g < G; g++) begin : g_grp
        logic hit;
        assign hit = pend_i[g] && !cap_q[g] && (fill_i || (sample_i && thr_i[g]));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_q[g] <= 1'b0;
                cnt_q[g] <= '0;
            end else if (clear_i) begin
                cap_q[g] <= 1'b0;
                cnt_q[g] <= '0;
            end else if (hit) begin
                cap_q[g] <= 1'b1;
                cnt_q[g] <= xcnt_i;
            end
        end

        assign cnt_o[g*CW +: CW] = cnt_q[g];

        assert_cap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_q[g] && !clear_i) |=> cap_q[g]);
        assert_cnt_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_q[g] && !clear_i) |=> $stable(cnt_q[g]));
        assert_fill_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_i && pend_i[g] && !clear_i) |=> cap_q[g]);
        assert_unpended_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !pend_i[g] |-> !cap_q[g]);
    end

    assign cap_o = cap_q;

endmodule

// File: rtl/ctsense_seq.sv
module ctsense_seq
    import ctsense_pkg::*;
#(
    parameter int GROUPS   = 8,
    parameter int CNT_W    = 16,
    parameter int DLY_W    = 8,
    parameter int SPR_W    = 4,
    parameter int DEAD_CYC = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [GROUPS-1:0]        elec_en_i,
    input  logic [GROUPS-1:0]        samp_en_i,
    input  logic [GROUPS-1:0]        off_i,
    input  logic [GROUPS-1:0]        burst_only_i,
    input  logic [CNT_W-1:0]         max_count_i,
    input  logic [DLY_W-1:0]         charge_dly_i,
    input  logic [DLY_W-1:0]         xfer_dly_i,
    input  logic [DLY_W-1:0]         disch_dly_i,
    input  logic                     spread_en_i,
    input  logic [SPR_W-1:0]         spread_min_i,
    input  logic [SPR_W-1:0]         spread_max_i,
    input  logic [GROUPS-1:0]        thr_i,
    output logic [GROUPS-1:0]        chg_o,
    output logic [GROUPS-1:0]        xfer_o,
    output logic [GROUPS-1:0]        low_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [GROUPS*CNT_W-1:0]  count_o
);

    localparam int XW = CNT_W + 1;
    localparam int LW = DLY_W + 1;
    localparam logic [LW-1:0] DEAD_LEN = LW'((DEAD_CYC < 1) ? 1 : DEAD_CYC);

    cts_state_e state_q, state_d;

    logic [GROUPS-1:0] elec_q, act_q, pend_q;
    logic [DLY_W-1:0]  chg_len_q, xfer_len_q;
    logic [CNT_W-1:0]  max_q;
    logic [XW-1:0]     xcnt_q;

    logic [GROUPS-1:0] pend_w, elec_w, act_w;
    logic [GROUPS-1:0] thr_s, cap;
    logic              accept, tmr_load, tmr_exp, sp_step, xcnt_inc, fill;
    logic [LW-1:0]     tmr_len, chg_load_len;
    logic [SPR_W-1:0]  sp_extra;
    logic              all_cap, over_max;

    assign pend_w = samp_en_i & ~off_i & ~burst_only_i;
    assign elec_w = elec_en_i & ~off_i;
    assign act_w  = (elec_en_i | samp_en_i) & ~off_i;

    assign chg_load_len = {1'b0, chg_len_q} + {{(LW-SPR_W){1'b0}}, sp_extra};
    assign all_cap      = ((cap & pend_q) == pend_q);
    assign over_max     = (xcnt_q > {1'b0, max_q});

    ctsense_sync #(.W(GROUPS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (thr_i),
        .q_o   (thr_s)
    );

    ctsense_timer #(.LW(LW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .len_i    (tmr_len),
        .expire_o (tmr_exp)
    );

    ctsense_spread #(.SW(SPR_W)) u_spread (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (accept),
        .en_i    (spread_en_i),
        .min_i   (spread_min_i),
        .max_i   (spread_max_i),
        .step_i  (sp_step),
        .extra_o (sp_extra)
    );

    ctsense_capture #(.G(GROUPS), .CW(CNT_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .sample_i (state_q == S_CHARGE),
        .fill_i   (fill),
        .thr_i    (thr_s),
        .pend_i   (pend_q),
        .xcnt_i   (xcnt_q[CNT_W-1:0]),
        .cap_o    (cap),
        .cnt_o    (count_o)
    );

    // next-state and phase control
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = '0;
        sp_step  = 1'b0;
        xcnt_inc = 1'b0;
        fill     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    accept = 1'b1;
                    if (pend_w != '0) begin
                        state_d  = S_DISCH;
                        tmr_load = 1'b1;
                        tmr_len  = {1'b0, disch_dly_i};
                    end else begin
                        state_d  = S_DONE;
                    end
                end
            end
            S_DISCH: begin
                if (tmr_exp) begin
                    state_d  = S_DEAD0;
                    tmr_load = 1'b1;
                    tmr_len  = DEAD_LEN;
                end
            end
            S_DEAD0: begin
                if (tmr_exp) begin
                    state_d  = S_CHARGE;
                    tmr_load = 1'b1;
                    tmr_len  = chg_load_len;
                    sp_step  = 1'b1;
                end
            end
            S_CHARGE: begin
                if (tmr_exp) begin
                    state_d  = S_DEAD1;
                    tmr_load = 1'b1;
                    tmr_len  = DEAD_LEN;
                end
            end
            S_DEAD1: begin
                if (tmr_exp) begin
                    state_d  = S_XFER;
                    tmr_load = 1'b1;
                    tmr_len  = {1'b0, xfer_len_q};
                    xcnt_inc = 1'b1;
                end
            end
            S_XFER: begin
                if (tmr_exp) begin
                    state_d  = S_DEAD2;
                    tmr_load = 1'b1;
                    tmr_len  = DEAD_LEN;
                end
            end
            S_DEAD2: begin
                if (tmr_exp) begin
                    if (all_cap) begin
                        state_d = S_DONE;
                    end else if (over_max) begin
                        fill    = 1'b1;
                        state_d = S_DONE;
                    end else begin
                        state_d  = S_CHARGE;
                        tmr_load = 1'b1;
                        tmr_len  = chg_load_len;
                        sp_step  = 1'b1;
                    end
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // burst configuration and transfer counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elec_q     <= '0;
            act_q      <= '0;
            pend_q     <= '0;
            chg_len_q  <= '0;
            xfer_len_q <= '0;
            max_q      <= '0;
            xcnt_q     <= '0;
        end else if (accept) begin
            elec_q     <= elec_w;
            act_q      <= act_w;
            pend_q     <= pend_w;
            chg_len_q  <= charge_dly_i;
            xfer_len_q <= xfer_dly_i;
            max_q      <= max_count_i;
            xcnt_q     <= '0;
        end else if (xcnt_inc) begin
            xcnt_q     <= xcnt_q + XW'(1);
        end
    end

    // outputs
    always_comb begin
        chg_o  = '0;
        xfer_o = '0;
        low_o  = '1;
        busy_o = (state_q != S_IDLE);
        done_o = (state_q == S_DONE);
        unique case (state_q)
            S_CHARGE: begin
                chg_o = elec_q;
                low_o = ~act_q;
            end
            S_XFER: begin
                xfer_o = act_q;
                low_o  = ~act_q;
            end
            S_DEAD0, S_DEAD1, S_DEAD2: begin
                low_o = ~act_q;
            end
            S_IDLE, S_DISCH, S_DONE: begin
                low_o = '1;
            end
            default: begin
                low_o = '1;
            end
        endcase
    end

    assert_dead_after_chg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg_o) |=> !(|xfer_o));
    assert_dead_after_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|xfer_o) |=> !(|chg_o));
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && state_q != S_DISCH) |=> (state_q != S_DISCH));
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (xcnt_q <= ({1'b0, max_q} + XW'(1))));

endmodule

// File: tb/ctsense_seq_tb_top.sv
`timescale 1ns/1ps
module ctsense_seq_tb_top;

    localparam int G  = 8;
    localparam int CW = 16;
    localparam int DW = 8;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          start_i = 0;
    logic [G-1:0]  elec_en_i = 0, samp_en_i = 0, off_i = 0, burst_only_i = 0;
    logic [CW-1:0] max_count_i = 0;
    logic [DW-1:0] charge_dly_i = 1, xfer_dly_i = 1, disch_dly_i = 1;
    logic          spread_en_i = 0;
    logic [SW-1:0] spread_min_i = 0, spread_max_i = 0;
    logic [G-1:0]  thr_i;
    logic [G-1:0]  chg_o, xfer_o, low_o;
    logic          busy_o, done_o;
    logic [G*CW-1:0] count_o;

    ctsense_seq #(.GROUPS(G), .CNT_W(CW), .DLY_W(DW), .SPR_W(SW), .DEAD_CYC(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .elec_en_i(elec_en_i), .samp_en_i(samp_en_i), .off_i(off_i),
        .burst_only_i(burst_only_i), .max_count_i(max_count_i),
        .charge_dly_i(charge_dly_i), .xfer_dly_i(xfer_dly_i), .disch_dly_i(disch_dly_i),
        .spread_en_i(spread_en_i), .spread_min_i(spread_min_i), .spread_max_i(spread_max_i),
        .thr_i(thr_i), .chg_o(chg_o), .xfer_o(xfer_o), .low_o(low_o),
        .busy_o(busy_o), .done_o(done_o), .count_o(count_o)
    );

    int checks = 0;
    int fails  = 0;

    // burst configuration held by the bench
    logic [G-1:0]  c_elec, c_samp, c_off, c_bo;
    int            c_max, c_cd, c_xd, c_dd;
    logic          c_sp;
    int            c_spmin, c_spmax;
    int            tgt [G];

    // monitor state, written only by the monitor
    logic          clr_req = 0;
    int            xedge [G];
    int            xpulses, nlen, cur_len, dones, cyc, first_chg, overlap, off_err, act;
    int            clen [8];
    logic [G-1:0]  chg_seen, xfer_seen, low2, cx2, pc, px;

    always @(negedge clk) begin
        if (clr_req) begin
            for (int g = 0; g < G; g++) xedge[g] = 0;
            xpulses = 0; nlen = 0; cur_len = 0; dones = 0; cyc = 1; first_chg = 0;
            overlap = 0; off_err = 0; act = 0; chg_seen = 0; xfer_seen = 0;
            low2 = 0; cx2 = 0;
        end else begin
            cyc++;
            for (int g = 0; g < G; g++)
                if (xfer_o[g] && !px[g]) xedge[g]++;
            if ((|xfer_o) && !(|px)) xpulses++;
            if (|chg_o) cur_len++;
            else if (|pc) begin
                if (nlen < 8) clen[nlen] = cur_len;
                nlen++;
                cur_len = 0;
            end
            if ((|chg_o) && first_chg == 0) first_chg = cyc;
            if (cyc == 2) begin low2 = low_o; cx2 = chg_o | xfer_o; end
            if ((|(chg_o & xfer_o)) || ((|pc) && (|xfer_o)) || ((|px) && (|chg_o))) overlap++;
            if (busy_o && ((((chg_o | xfer_o) & c_off) != 0) || ((~low_o & c_off) != 0))) off_err++;
            if ((|chg_o) || (|xfer_o)) act++;
            chg_seen  = chg_seen | chg_o;
            xfer_seen = xfer_seen | xfer_o;
            if (done_o) dones++;
        end
        for (int g = 0; g < G; g++) thr_i[g] = (xedge[g] >= tgt[g]);
        pc = chg_o;
        px = xfer_o;
    end

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic logic [G-1:0] pend_of();
        return c_samp & ~c_off & ~c_bo;
    endfunction

    // total number of transfers in a burst
    function automatic int total_xfers();
        int mt = -1;
        for (int g = 0; g < G; g++)
            if (pend_of()[g] && tgt[g] > mt) mt = tgt[g];
        if (mt < 0) return 0;
        return (mt <= c_max) ? mt + 1 : c_max + 1;
    endfunction

    function automatic int exp_count(input int g);
        int n = total_xfers();
        if (!pend_of()[g]) return 0;
        return (tgt[g] <= n - 1) ? tgt[g] : c_max + 1;
    endfunction

    task automatic run_burst(input bit inject);
        int waited;
        @(posedge clk); #1;
        clr_req = 1;
        elec_en_i = c_elec; samp_en_i = c_samp; off_i = c_off; burst_only_i = c_bo;
        max_count_i = CW'(c_max); charge_dly_i = DW'(c_cd); xfer_dly_i = DW'(c_xd);
        disch_dly_i = DW'(c_dd); spread_en_i = c_sp;
        spread_min_i = SW'(c_spmin); spread_max_i = SW'(c_spmax);
        start_i = 1;
        @(posedge clk); #1;
        clr_req = 0;
        start_i = 0;
        waited = 0;
        while (dones == 0 && waited < 20000) begin
            @(posedge clk); #1;
            waited++;
            if (inject && waited == 12) begin
                start_i = 1; samp_en_i = ~c_samp; max_count_i = 3; charge_dly_i = 9;
            end
            if (inject && waited == 13) begin
                start_i = 0; samp_en_i = c_samp; max_count_i = CW'(c_max); charge_dly_i = DW'(c_cd);
            end
        end
        start_i = 0;
        if (dones == 0) check(0, "R13 watchdog on burst", 0, 1);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic verify(input string tag);
        logic [G-1:0] pend = pend_of();
        for (int g = 0; g < G; g++)
            check(count_o[g*CW +: CW] == CW'(exp_count(g)), tag,
                  int'(count_o[g*CW +: CW]), exp_count(g));
        check(dones == 1, "R13 one done pulse", dones, 1);
        check(low_o == '1 && !busy_o && !done_o, "R13 idle after burst", int'(low_o), 255);
        check(off_err == 0, "R5 off group quiet", off_err, 0);
        if (pend != 0) begin
            check(overlap == 0, "R2 dead time separation", overlap, 0);
            check(xpulses == total_xfers(), "R7 R8 transfer total", xpulses, total_xfers());
            check(chg_seen == (c_elec & ~c_off), "R3 charge mask", int'(chg_seen), int'(c_elec & ~c_off));
            check(xfer_seen == ((c_elec | c_samp) & ~c_off), "R3 transfer mask",
                  int'(xfer_seen), int'((c_elec | c_samp) & ~c_off));
        end
    endtask

    task automatic defaults();
        c_elec = '1; c_samp = '1; c_off = 0; c_bo = 0; c_max = 20;
        c_cd = 2; c_xd = 1; c_dd = 3; c_sp = 0; c_spmin = 0; c_spmax = 0;
        for (int g = 0; g < G; g++) tgt[g] = g;
    endtask

    initial begin
        #(4 * 190000);
        check(0, "R13 global watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c7a1));
        defaults();
        c_off = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(chg_o == 0 && xfer_o == 0, "R1 switches open", int'(chg_o | xfer_o), 0);
        check(low_o == '1, "R1 drive low", int'(low_o), 255);
        check(!busy_o && !done_o && count_o == 0, "R1 status and counts", int'(busy_o), 0);
        rst_n = 1;
        repeat (2) @(posedge clk);

        // R2 R6 R7: staggered thresholds, early end
        defaults();
        run_burst(0);
        verify("R6 staggered capture");
        check(first_chg == c_dd + 3, "R2 first charge timing", first_chg, c_dd + 3);
        check(low2 == '1 && cx2 == 0, "R2 discharge all low", int'(low2), 255);
        check(clen[0] == c_cd && clen[1] == c_cd, "R11 no spread", clen[1], c_cd);

        // R8: timeout
        defaults();
        c_max = 10; tgt[1] = 30; tgt[4] = 11; tgt[6] = 10;
        run_burst(0);
        verify("R8 timeout fill");

        // R4 R5: switched-off and burst-only groups
        defaults();
        c_off = 8'h81; c_bo = 8'h10; tgt[0] = 2; tgt[7] = 3;
        run_burst(0);
        verify("R4 R5 masked groups");

        // R10: clear on new burst
        defaults();
        tgt[2] = 5;
        run_burst(0);
        check(count_o[2*CW +: CW] == 5, "R10 first burst value", int'(count_o[2*CW +: CW]), 5);
        c_bo = 8'h04;
        run_burst(0);
        check(count_o[2*CW +: CW] == 0, "R10 cleared", int'(count_o[2*CW +: CW]), 0);
        verify("R10 second burst");

        // R9: empty pending set
        defaults();
        c_bo = '1;
        run_burst(0);
        check(act == 0, "R9 no switch activity", act, 0);
        verify("R9 empty burst");

        // R11: spread sequence
        defaults();
        c_sp = 1; c_spmin = 0; c_spmax = 3; c_cd = 2;
        for (int g = 0; g < G; g++) tgt[g] = 6;
        run_burst(0);
        check(clen[0] == 3, "R11 charge 1", clen[0], 3);
        check(clen[1] == 4, "R11 charge 2", clen[1], 4);
        check(clen[2] == 2, "R11 charge 3", clen[2], 2);
        check(clen[3] == 3, "R11 charge 4", clen[3], 3);
        verify("R11 spread counts");

        // R12: start and config changes while busy
        defaults();
        for (int g = 0; g < G; g++) tgt[g] = 8 + g;
        run_burst(1);
        verify("R12 busy start ignored");

        // R3 R6: random configurations
        for (int t = 0; t < 24; t++) begin
            c_elec = G'($urandom); c_samp = G'($urandom) | G'(1 << (t % G));
            c_off = G'($urandom) & G'($urandom); c_bo = G'($urandom) & G'($urandom);
            c_max = 4 + ($urandom % 16); c_cd = 1 + ($urandom % 4);
            c_xd = 1 + ($urandom % 3); c_dd = 1 + ($urandom % 4);
            c_sp = 1'($urandom); c_spmin = $urandom % 3; c_spmax = c_spmin + 2 + ($urandom % 4);
            for (int g = 0; g < G; g++) tgt[g] = $urandom % 24;
            run_burst(0);
            verify("R6 random capture");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule